// File: doc/BRIEF.md
# I2C Register-Mapped I/O Expander Slave

This block is the serial front end of an 8-bit I/O expander. It watches an I2C bus, using SDA and SCL inputs and a pull-low enable for each line, and answers a 7-bit device address. The upper four bits of that address are fixed and the lower three come from strap inputs. A write carries a command byte that points at one of four registers, followed by any number of data bytes. A read returns the register the pointer last selected.

The output, polarity and configuration registers leave the block as plain buses to the port logic. The input register is the live port value, corrected by the polarity mask. Each time a byte of the input register completes on the bus, the block raises a one-cycle strobe that the interrupt logic uses to clear itself. Both bus lines pass through a synchronizer clocked by the system clock. START and STOP are recognised from the synchronized levels. The block never stretches the clock.

Top module: `i2c_ioexp_slave`

## Requirements
- R1: After reset, out_reg is 0xFF, pol_reg is 0x00 and cfg_reg is 0xFF, and neither sda_pull nor scl_pull is asserted. scl_pull stays low at all times.
- R2: The slave responds only to the address {0111, addr_sel[2], addr_sel[1], addr_sel[0]}, sent MSB first and followed by the R/W bit, where 0 means write. On a match it pulls SDA low in the ninth bit. On any other address it does not acknowledge and ignores every bit until the next START, so no register changes.
- R3: In a write, the byte after the address is the command byte, and it is acknowledged. Its two low bits set the pointer: 0 is the input register, 1 is output, 2 is polarity and 3 is configuration. The six upper bits are ignored, so 0x06 selects polarity.
- R4: Every data byte of a write is acknowledged and stored into the register the pointer selects. The store happens on the SCL fall that ends the byte's acknowledge bit. When a write holds several data bytes, each one overwrites the last, so the final byte remains.
- R5: Data bytes written while the pointer is 0 are acknowledged and change no register.
- R6: A read returns the selected register MSB first. The slave keeps sending the same register while the master acknowledges each byte, and it releases the bus after a master NACK. The input register reads as port_in XOR pol_reg, sampled when the byte starts.
- R7: in_read_ack pulses for exactly one clock at the acknowledge or NACK bit of every input-register byte that is read. It never pulses for reads of the other registers.
- R8: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A STOP returns the slave to idle and drops any partial byte. A repeated START begins a new address phase and keeps the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| addr_sel | input | 3 | Low three address bits from strap pins |
| port_in | input | 8 | Live port pin levels |
| sda_pull | output | 1 | Pull SDA low when 1 |
| scl_pull | output | 1 | Pull SCL low when 1 (always 0) |
| out_reg | output | 8 | Output port register |
| pol_reg | output | 8 | Polarity inversion register |
| cfg_reg | output | 8 | Configuration register (1 = input) |
| in_read_ack | output | 1 | One-cycle strobe when an input-register byte is read |

## Verification
The assertions assume a bus slow enough for the synchronizer: every SCL level lasts many system clocks, and SDA moves only while SCL is low, except to form START and STOP. They also assume the master never issues a STOP while the slave is driving a data bit. The bench master runs each quarter bit for five clocks, changes SDA a quarter period after each SCL fall, and NACKs the last byte of every read before it issues STOP. It also pulses both lines only in those legal orders, including the aborted-byte STOP and the repeated START.

// File: rtl/i2c_ioexp_slave.sv
module i2c_ioexp_slave #(
  parameter int SYNC_STAGES = 2,
  parameter logic [3:0] ADDR_HI = 4'b0111
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] addr_sel,
  input  logic [7:0] port_in,
  output logic       sda_pull,
  output logic       scl_pull,
  output logic [7:0] out_reg,
  output logic [7:0] pol_reg,
  output logic [7:0] cfg_reg,
  output logic       in_read_ack
);
  localparam int BW = 8;
  localparam int CW = $clog2(BW + 1);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RXACK, S_TX, S_TXACK, S_IGN} st_t;
  typedef enum logic [1:0] {K_ADDR, K_CMD, K_DATA} kind_t;

  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;
  wire scl_s = scl_pipe[SYNC_STAGES-1];
  wire sda_s = sda_pipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end

  wire start    = scl_s && scl_q && sda_q && !sda_s;
  wire stop     = scl_s && scl_q && !sda_q && sda_s;
  wire scl_rise = scl_s && !scl_q;
  wire scl_fall = !scl_s && scl_q;

  st_t           state;
  kind_t         kind;
  logic [CW-1:0] bitcnt;
  logic [BW-1:0] shreg;
  logic [1:0]    ptr;
  logic          rw, nack;
  logic [BW-1:0] rd_val;

  always_comb
    case (ptr)
      2'd0:    rd_val = port_in ^ pol_reg;
      2'd1:    rd_val = out_reg;
      2'd2:    rd_val = pol_reg;
      default: rd_val = cfg_reg;
    endcase

  wire addr_hit = shreg[BW-1:1] == {ADDR_HI, addr_sel};
  wire commit   = state == S_RXACK && kind == K_DATA && scl_fall;

  assign scl_pull = 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state       <= S_IDLE;
      kind        <= K_ADDR;
      bitcnt      <= '0;
      shreg       <= '0;
      ptr         <= 2'd0;
      rw          <= 1'b0;
      nack        <= 1'b1;
      sda_pull    <= 1'b0;
      in_read_ack <= 1'b0;
    end else begin
      in_read_ack <= 1'b0;
      if (start) begin
        state    <= S_RX;
        kind     <= K_ADDR;
        bitcnt   <= '0;
        sda_pull <= 1'b0;
      end else if (stop) begin
        state    <= S_IDLE;
        sda_pull <= 1'b0;
      end else begin
        case (state)
          S_RX:
            if (scl_rise && bitcnt != CW'(BW)) begin
              shreg  <= {shreg[BW-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == CW'(BW)) begin
              if (kind == K_ADDR && !addr_hit) begin
                state <= S_IGN;
              end else begin
                if (kind == K_ADDR) rw <= shreg[0];
                if (kind == K_CMD)  ptr <= shreg[1:0];
                state    <= S_RXACK;
                sda_pull <= 1'b1;
              end
            end
          S_RXACK:
            if (scl_fall) begin
              bitcnt <= '0;
              if (kind == K_ADDR && rw) begin
                shreg    <= rd_val;
                sda_pull <= ~rd_val[BW-1];
                state    <= S_TX;
              end else begin
                sda_pull <= 1'b0;
                state    <= S_RX;
                kind     <= (kind == K_ADDR) ? K_CMD : K_DATA;
              end
            end
          S_TX:
            if (scl_fall) begin
              if (bitcnt == CW'(BW - 1)) begin
                state    <= S_TXACK;
                sda_pull <= 1'b0;
              end else begin
                bitcnt   <= bitcnt + 1'b1;
                shreg    <= {shreg[BW-2:0], 1'b0};
                sda_pull <= ~shreg[BW-2];
              end
            end
          S_TXACK:
            if (scl_rise) begin
              nack        <= sda_s;
              in_read_ack <= ptr == 2'd0;
            end else if (scl_fall) begin
              if (nack) begin
                state <= S_IGN;
              end else begin
                shreg    <= rd_val;
                sda_pull <= ~rd_val[BW-1];
                bitcnt   <= '0;
                state    <= S_TX;
              end
            end
          default: ;
        endcase
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_reg <= '1;
      pol_reg <= '0;
      cfg_reg <= '1;
    end else if (commit) begin
      case (ptr)
        2'd1:    out_reg <= shreg;
        2'd2:    pol_reg <= shreg;
        2'd3:    cfg_reg <= shreg;
        default: ;
      endcase
    end

  a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    in_read_ack |=> !in_read_ack);

  a_r2_quiet_when_unaddressed: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE || state == S_IGN) |-> !sda_pull);

  a_r8_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> state == S_IDLE);

  a_r6_hold_while_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TX && scl_s && !start && !stop) |=> $stable(sda_pull));

  a_r4_regs_move_on_ack_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({out_reg, pol_reg, cfg_reg}) |-> $past(state == S_RXACK && kind == K_DATA));

  a_r5_pointer0_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RXACK && kind == K_DATA && ptr == 2'd0) |=> $stable({out_reg, pol_reg, cfg_reg}));

  a_r1_no_clock_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_pull);
endmodule

// File: tb/tb_i2c_ioexp_slave.sv
module tb_i2c_ioexp_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] addr_sel = 3'b000;
  logic [7:0] port_in = 8'h00;
  logic sda_pull, scl_pull, in_read_ack;
  logic [7:0] out_reg, pol_reg, cfg_reg;
  logic scl_line, sda_line;

  always #5 clk = ~clk;

  assign scl_line = scl_m & ~scl_pull;
  assign sda_line = sda_m & ~sda_pull;

  i2c_ioexp_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .addr_sel(addr_sel), .port_in(port_in), .sda_pull(sda_pull), .scl_pull(scl_pull),
    .out_reg(out_reg), .pol_reg(pol_reg), .cfg_reg(cfg_reg), .in_read_ack(in_read_ack)
  );

  int checks = 0, errors = 0;
  int clk_checks = 0, clk_errors = 0;
  int strobes = 0, exp_strobes = 0;
  int cyc = 0, last_upd = 0;
  logic [7:0] m_out = 8'hFF, m_pol = 8'h00, m_cfg = 8'hFF;
  logic [1:0] m_ptr = 2'd0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (in_read_ack) strobes <= strobes + 1;
    if (rst_n && cyc - last_upd > 8) begin
      clk_checks <= clk_checks + 1;
      if (out_reg !== m_out || pol_reg !== m_pol || cfg_reg !== m_cfg || scl_pull !== 1'b0) begin
        clk_errors <= clk_errors + 1;
        $display("FAIL R4 per-clock regs actual=%h/%h/%h expected=%h/%h/%h",
                 out_reg, pol_reg, cfg_reg, m_out, m_pol, m_cfg);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic q();
    repeat (5) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
    end
  endtask

  task automatic write_byte(input logic [7:0] b, input bit is_data, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); ack = ~sda_line; q(); scl_m = 1'b0;
    if (is_data && ack) begin
      case (m_ptr)
        2'd1: m_out = b;
        2'd2: m_pol = b;
        2'd3: m_cfg = b;
        default: ;
      endcase
      last_upd = cyc;
    end
    q();
  endtask

  task automatic read_byte(input logic nack_bit, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(); scl_m = 1'b1; q(); b[i] = sda_line; q(); scl_m = 1'b0;
    end
    q(); sda_m = nack_bit; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q(); sda_m = 1'b1;
  endtask

  function automatic logic [7:0] dev_addr();
    return {4'b0111, addr_sel, 1'b0};
  endfunction

  task automatic wr(input logic [7:0] cmd, input logic [7:0] data[$]);
    logic ack;
    i2c_start();
    write_byte(dev_addr(), 0, ack); chk("R2 address ack", ack, 1);
    write_byte(cmd, 0, ack); chk("R3 command ack", ack, 1);
    m_ptr = cmd[1:0];
    foreach (data[i]) begin
      write_byte(data[i], 1, ack); chk("R4 data ack", ack, 1);
    end
    i2c_stop();
  endtask

  function automatic logic [7:0] m_read();
    case (m_ptr)
      2'd0: return port_in ^ m_pol;
      2'd1: return m_out;
      2'd2: return m_pol;
      default: return m_cfg;
    endcase
  endfunction

  task automatic rd(input logic [7:0] cmd, input int n, input string tag);
    logic ack;
    logic [7:0] b;
    i2c_start();
    write_byte(dev_addr(), 0, ack); chk("R2 address ack", ack, 1);
    write_byte(cmd, 0, ack); chk("R3 command ack", ack, 1);
    m_ptr = cmd[1:0];
    i2c_start();
    write_byte(dev_addr() | 8'h01, 0, ack); chk("R8 repeated start read ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      read_byte(i == n - 1, b);
      chk(tag, b, m_read());
      if (m_ptr == 2'd0) exp_strobes++;
    end
    i2c_stop();
    q();
    chk("R7 strobe count", strobes, exp_strobes);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks + clk_checks + 1, errors + clk_errors + 1);
    $finish;
  end

  initial begin
    logic ack;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset out", out_reg, 8'hFF);
    chk("R1 reset pol", pol_reg, 8'h00);
    chk("R1 reset cfg", cfg_reg, 8'hFF);
    chk("R1 reset sda_pull", sda_pull, 0);

    wr(8'h01, '{8'hA5});
    chk("R4 output written", out_reg, 8'hA5);
    wr(8'h02, '{8'h0F, 8'h3C, 8'h81});
    chk("R4 last byte wins", pol_reg, 8'h81);
    wr(8'h03, '{8'h55});
    chk("R3 config selected", cfg_reg, 8'h55);
    wr(8'h00, '{8'h12, 8'h34});
    chk("R5 output untouched", out_reg, 8'hA5);
    chk("R5 polarity untouched", pol_reg, 8'h81);
    chk("R5 config untouched", cfg_reg, 8'h55);

    i2c_start();
    write_byte({7'h21, 1'b0}, 0, ack); chk("R2 wrong address nack", ack, 0);
    write_byte(8'h01, 0, ack); chk("R2 ignored command", ack, 0);
    write_byte(8'h00, 0, ack); chk("R2 ignored data", ack, 0);
    i2c_stop();
    chk("R2 output unchanged", out_reg, 8'hA5);

    rd(8'h01, 2, "R6 read output");
    rd(8'h03, 1, "R6 read config");
    port_in = 8'h96;
    rd(8'h00, 2, "R6 read input xor polarity");
    port_in = 8'h3B;
    rd(8'h04, 3, "R6 read input again");
    wr(8'h06, '{8'hC3});
    chk("R3 high command bits ignored", pol_reg, 8'hC3);
    rd(8'h02, 1, "R6 read polarity");

    i2c_start();
    write_byte(dev_addr(), 0, ack); chk("R8 address ack", ack, 1);
    write_byte(8'h01, 0, ack); chk("R8 command ack", ack, 1);
    m_ptr = 2'd1;
    send_bits(8'h00, 4);
    i2c_stop();
    q();
    chk("R8 partial byte dropped", out_reg, 8'hA5);
    chk("R8 bus released", sda_pull, 0);

    addr_sel = 3'b101;
    wr(8'h01, '{8'h5A});
    chk("R2 strap address used", out_reg, 8'h5A);
    chk("R1 no clock stretch", scl_pull, 0);

    repeat (20) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks + clk_checks, errors + clk_errors);
    $finish;
  end
endmodule